// File: doc/BRIEF.md
# SMBus Host Command Sequencer

This block sits between a host that issues whole SMBus transactions and a byte-level I2C master. The host presents one command: a target address, a command kind, a command code, up to two data bytes, and a block length. The sequencer expands that command into the exact series of byte primitives the transaction needs. The primitives are start (address plus direction), send a byte, receive a byte, not-acknowledge and stop. It issues them one at a time over a valid/ready port. Each primitive stays on the port until the lower master takes it.

Received bytes are collected into a 16-bit result. Block data goes through a 32-entry byte buffer. The host fills that buffer before a block write and reads it back after a block read. When the stop primitive has been taken, the sequencer raises a one-cycle completion pulse. The pulse carries the result, the effective block length and an error flag for command kinds it does not know.

Top module: `smbus_cmd_seq`

## Requirements
- R1: Kind 0 (quick) issues start with byte {address, cmd_quick_rd}, then stop, and nothing else. Primitive op codes are 0 start, 1 send, 2 receive, 3 not-acknowledge, 4 stop. The start byte carries the 7-bit address in bits 7:1 and the direction in bit 0, with 1 meaning read.
- R2: Kind 1 (send byte) issues start-write, send of the command code, then stop.
- R3: Kind 2 (receive byte) issues start-read, one receive, not-acknowledge, then stop. The received byte appears in res_data[7:0] and res_data[15:8] is zero.
- R4: Kind 3 (write byte) and kind 5 (write word) issue start-write, the command code, then the data bytes, then stop. Write byte sends cmd_wdata[7:0]. Write word sends cmd_wdata[7:0] and then cmd_wdata[15:8].
- R5: Kind 4 (read byte) and kind 6 (read word) issue start-write, the command code, a repeated start-read, one or two receives, not-acknowledge, then stop. The first received byte lands in res_data[7:0] and the second in res_data[15:8]. A read byte leaves res_data[15:8] at zero.
- R6: Kind 7 (block write) clamps cmd_blen to 32. It issues start-write, the command code, the clamped length, then that many buffer bytes from index 0 upward, then stop. res_len reports the clamped length.
- R7: Kind 8 (block read) issues start-write, the command code, start-read, then one receive whose byte is the length. A length above 32 counts as 0. It then issues that many receives stored into buffer index 0 upward, then not-acknowledge and stop. res_len reports the effective length.
- R8: Kinds 9 to 15 issue no primitive. done is raised with done_err set in the cycle after acceptance.
- R9: While prim_valid is high and prim_ready is low, prim_op and prim_byte hold their values into the next cycle.
- R10: cmd_ready is high only while idle, and a command is taken only then. Command inputs that change while busy have no effect. done is a single-cycle pulse in the cycle after the stop primitive is taken, and cmd_ready returns in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Sequencer idle, command taken when valid |
| cmd_kind | input | 4 | Command kind code (0 to 8 defined) |
| cmd_addr | input | 7 | Target address |
| cmd_quick_rd | input | 1 | Direction bit for the quick command |
| cmd_code | input | 8 | Command code, or data byte for send byte |
| cmd_wdata | input | 16 | Write data, low byte sent first |
| cmd_blen | input | 8 | Requested block write length |
| host_buf_we | input | 1 | Host write strobe into the block buffer (idle only) |
| host_buf_widx | input | 5 | Host write index |
| host_buf_wdata | input | 8 | Host write byte |
| host_buf_ridx | input | 5 | Host read index |
| host_buf_rdata | output | 8 | Buffer byte at host_buf_ridx |
| prim_valid | output | 1 | Primitive offered |
| prim_ready | input | 1 | Primitive taken by the lower master |
| prim_op | output | 3 | Primitive op code |
| prim_byte | output | 8 | Start byte or byte to send, zero otherwise |
| prim_rdata | input | 8 | Received byte, valid when a receive is taken |
| done | output | 1 | Completion pulse |
| done_err | output | 1 | Unknown command kind, valid with done |
| res_data | output | 16 | Collected read data |
| res_len | output | 6 | Effective block length |

## Verification
The hardest situations to reach are the block-read length edges. A returned length byte of 33 must collapse to zero receives, while exactly 32 must fill the whole buffer. The bench reaches both by scripting the length byte that its responder model hands back on the first receive. It also reaches them by stalling the ready line for a varying number of cycles per primitive, so each primitive is seen both taken at once and held. To show that busy-time command inputs are ignored, a read-word transaction is run while cmd_valid stays high with a different address and kind. The bench then checks that only the original primitive trace appears and that the sequencer returns to idle without starting a second transaction.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;

  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  // command kinds
  localparam logic [3:0] K_QUICK     = 4'd0;
  localparam logic [3:0] K_SEND_BYTE = 4'd1;
  localparam logic [3:0] K_RECV_BYTE = 4'd2;
  localparam logic [3:0] K_WR_BYTE   = 4'd3;
  localparam logic [3:0] K_RD_BYTE   = 4'd4;
  localparam logic [3:0] K_WR_WORD   = 4'd5;
  localparam logic [3:0] K_RD_WORD   = 4'd6;
  localparam logic [3:0] K_BLK_WR    = 4'd7;
  localparam logic [3:0] K_BLK_RD    = 4'd8;

  // primitive op codes
  localparam logic [2:0] OP_START = 3'd0;
  localparam logic [2:0] OP_SEND  = 3'd1;
  localparam logic [2:0] OP_RECV  = 3'd2;
  localparam logic [2:0] OP_NACK  = 3'd3;
  localparam logic [2:0] OP_STOP  = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE,
    S_START_W,
    S_CODE,
    S_BLEN,
    S_WDATA,
    S_START_R,
    S_RLEN,
    S_RECV,
    S_NACK,
    S_STOP,
    S_DONE
  } st_e;

  function automatic logic kind_known(input logic [3:0] k);
    return k <= K_BLK_RD;
  endfunction

  // requested write length limited to the buffer size
  function automatic int clamp_len(input logic [BYTE_W-1:0] v, input int lim);
    return (int'(v) > lim) ? lim : int'(v);
  endfunction

  // returned read length: anything beyond the buffer becomes zero
  function automatic int sane_rd_len(input logic [BYTE_W-1:0] v, input int lim);
    return (int'(v) > lim) ? 0 : int'(v);
  endfunction

  // data bytes moved by the fixed-size kinds
  function automatic int fixed_len(input logic [3:0] k);
    case (k)
      K_RECV_BYTE, K_WR_BYTE, K_RD_BYTE: return 1;
      K_WR_WORD, K_RD_WORD:              return 2;
      default:                           return 0;
    endcase
  endfunction

  function automatic st_e first_state(input logic [3:0] k);
    return (k == K_RECV_BYTE) ? S_START_R : S_START_W;
  endfunction

  function automatic logic [BYTE_W-1:0] start_byte(input logic [ADDR_W-1:0] a,
                                                   input logic rd);
    return {a, rd};
  endfunction

endpackage

// File: rtl/smbus_blk_buf.sv
module smbus_blk_buf #(
  parameter int DEPTH = 32,
  parameter int NRD   = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [7:0]                 wr_data,
  input  logic [NRD-1:0][IDX_W-1:0]  rd_idx,
  output logic [NRD-1:0][7:0]        rd_data
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = mem[rd_idx[p]];
  end

endmodule

// File: rtl/smbus_seq_step.sv
module smbus_seq_step
  import smbus_seq_pkg::*;
(
  input  st_e        cur,
  input  logic [3:0] kind,
  input  logic       last,
  input  logic       len_zero,
  output st_e        nxt
);

  always_comb begin
    nxt = cur;
    case (cur)
      S_START_W: nxt = (kind == K_QUICK) ? S_STOP : S_CODE;
      S_CODE: begin
        case (kind)
          K_SEND_BYTE:          nxt = S_STOP;
          K_WR_BYTE, K_WR_WORD: nxt = S_WDATA;
          K_BLK_WR:             nxt = S_BLEN;
          default:              nxt = S_START_R;
        endcase
      end
      S_BLEN:    nxt = len_zero ? S_STOP : S_WDATA;
      S_WDATA:   nxt = last ? S_STOP : S_WDATA;
      S_START_R: nxt = (kind == K_BLK_RD) ? S_RLEN : S_RECV;
      S_RLEN:    nxt = len_zero ? S_NACK : S_RECV;
      S_RECV:    nxt = last ? S_NACK : S_RECV;
      S_NACK:    nxt = S_STOP;
      S_STOP:    nxt = S_DONE;
      default:   nxt = cur;
    endcase
  end

endmodule

// File: rtl/smbus_prim_enc.sv
module smbus_prim_enc
  import smbus_seq_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  st_e               state,
  input  logic [3:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic              quick_rd,
  input  logic [7:0]        code,
  input  logic [15:0]       wdata,
  input  logic [LEN_W-1:0]  wlen,
  input  logic              word_hi,
  input  logic [7:0]        buf_byte,
  output logic              valid,
  output logic [2:0]        op,
  output logic [7:0]        pbyte
);

  logic [7:0] fixed_byte;
  assign fixed_byte = word_hi ? wdata[15:8] : wdata[7:0];

  always_comb begin
    valid = 1'b1;
    op    = OP_STOP;
    pbyte = '0;
    case (state)
      S_START_W: begin
        op    = OP_START;
        pbyte = start_byte(addr, (kind == K_QUICK) ? quick_rd : 1'b0);
      end
      S_START_R: begin
        op    = OP_START;
        pbyte = start_byte(addr, 1'b1);
      end
      S_CODE: begin
        op    = OP_SEND;
        pbyte = code;
      end
      S_BLEN: begin
        op    = OP_SEND;
        pbyte = 8'(wlen);
      end
      S_WDATA: begin
        op    = OP_SEND;
        pbyte = (kind == K_BLK_WR) ? buf_byte : fixed_byte;
      end
      S_RLEN, S_RECV: op = OP_RECV;
      S_NACK:         op = OP_NACK;
      S_STOP:         op = OP_STOP;
      default:        valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/smbus_cmd_seq.sv
module smbus_cmd_seq
  import smbus_seq_pkg::*;
#(
  parameter int BLK_MAX = 32,
  localparam int IDX_W = $clog2(BLK_MAX),
  localparam int LEN_W = $clog2(BLK_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [3:0]        cmd_kind,
  input  logic [6:0]        cmd_addr,
  input  logic              cmd_quick_rd,
  input  logic [7:0]        cmd_code,
  input  logic [15:0]       cmd_wdata,
  input  logic [7:0]        cmd_blen,
  input  logic              host_buf_we,
  input  logic [IDX_W-1:0]  host_buf_widx,
  input  logic [7:0]        host_buf_wdata,
  input  logic [IDX_W-1:0]  host_buf_ridx,
  output logic [7:0]        host_buf_rdata,
  output logic              prim_valid,
  input  logic              prim_ready,
  output logic [2:0]        prim_op,
  output logic [7:0]        prim_byte,
  input  logic [7:0]        prim_rdata,
  output logic              done,
  output logic              done_err,
  output logic [15:0]       res_data,
  output logic [LEN_W-1:0]  res_len
);

  st_e               state, nxt_state;
  logic [3:0]        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic              qrd_q;
  logic [7:0]        code_q;
  logic [15:0]       wdata_q;
  logic [LEN_W-1:0]  wlen_q, n_q, cnt;
  logic              err_q;

  // named events used by the checker
  logic             accept_evt, fire, stop_evt;
  logic             last, len_zero, seq_we;
  logic [LEN_W-1:0] rlen_s, req_wlen;

  assign accept_evt = (state == S_IDLE) && cmd_valid;
  assign fire       = prim_valid && prim_ready;
  assign stop_evt   = fire && (state == S_STOP);
  assign rlen_s     = LEN_W'(sane_rd_len(prim_rdata, BLK_MAX));
  assign req_wlen   = LEN_W'(clamp_len(cmd_blen, BLK_MAX));
  assign last       = (LEN_W'(cnt + 1'b1) == n_q);
  assign len_zero   = (state == S_BLEN) ? (wlen_q == '0) : (rlen_s == '0);
  assign seq_we     = fire && (state == S_RECV) && (kind_q == K_BLK_RD);

  // block buffer: port 0 feeds the sequencer, port 1 the host
  logic                      buf_we;
  logic [IDX_W-1:0]          buf_widx;
  logic [7:0]                buf_wdata;
  logic [1:0][IDX_W-1:0]     buf_ridx;
  logic [1:0][7:0]           buf_rdata;

  assign buf_we      = seq_we || (host_buf_we && (state == S_IDLE));
  assign buf_widx    = seq_we ? cnt[IDX_W-1:0] : host_buf_widx;
  assign buf_wdata   = seq_we ? prim_rdata : host_buf_wdata;
  assign buf_ridx[0] = cnt[IDX_W-1:0];
  assign buf_ridx[1] = host_buf_ridx;
  assign host_buf_rdata = buf_rdata[1];

  smbus_blk_buf #(.DEPTH(BLK_MAX), .NRD(2)) u_buf (
    .clk     (clk),
    .wr_en   (buf_we),
    .wr_idx  (buf_widx),
    .wr_data (buf_wdata),
    .rd_idx  (buf_ridx),
    .rd_data (buf_rdata)
  );

  smbus_seq_step u_step (
    .cur      (state),
    .kind     (kind_q),
    .last     (last),
    .len_zero (len_zero),
    .nxt      (nxt_state)
  );

  smbus_prim_enc #(.LEN_W(LEN_W)) u_enc (
    .state    (state),
    .kind     (kind_q),
    .addr     (addr_q),
    .quick_rd (qrd_q),
    .code     (code_q),
    .wdata    (wdata_q),
    .wlen     (wlen_q),
    .word_hi  (cnt[0]),
    .buf_byte (buf_rdata[0]),
    .valid    (prim_valid),
    .op       (prim_op),
    .pbyte    (prim_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      kind_q   <= '0;
      addr_q   <= '0;
      qrd_q    <= 1'b0;
      code_q   <= '0;
      wdata_q  <= '0;
      wlen_q   <= '0;
      n_q      <= '0;
      cnt      <= '0;
      err_q    <= 1'b0;
      res_data <= '0;
      res_len  <= '0;
    end else if (accept_evt) begin
      kind_q   <= cmd_kind;
      addr_q   <= cmd_addr;
      qrd_q    <= cmd_quick_rd;
      code_q   <= cmd_code;
      wdata_q  <= cmd_wdata;
      wlen_q   <= req_wlen;
      n_q      <= (cmd_kind == K_BLK_WR) ? req_wlen : LEN_W'(fixed_len(cmd_kind));
      cnt      <= '0;
      err_q    <= !kind_known(cmd_kind);
      res_data <= '0;
      res_len  <= (cmd_kind == K_BLK_WR) ? req_wlen : '0;
      state    <= kind_known(cmd_kind) ? first_state(cmd_kind) : S_DONE;
    end else if (state == S_DONE) begin
      state <= S_IDLE;
    end else if (fire) begin
      state <= nxt_state;
      case (state)
        S_WDATA: cnt <= cnt + 1'b1;
        S_RLEN: begin
          n_q     <= rlen_s;
          res_len <= rlen_s;
          cnt     <= '0;
        end
        S_RECV: begin
          cnt <= cnt + 1'b1;
          if (kind_q != K_BLK_RD) begin
            if (cnt[0]) res_data[15:8] <= prim_rdata;
            else        res_data[7:0]  <= prim_rdata;
          end
        end
        default: ;
      endcase
    end
  end

  assign cmd_ready = (state == S_IDLE);
  assign done      = (state == S_DONE);
  assign done_err  = done && err_q;

endmodule

// File: rtl/smbus_cmd_seq_chk.sv
module smbus_cmd_seq_chk #(
  parameter int BLK_MAX = 32,
  localparam int LEN_W = $clog2(BLK_MAX + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_ready,
  input logic             prim_valid,
  input logic             prim_ready,
  input logic [2:0]       prim_op,
  input logic [7:0]       prim_byte,
  input logic             done,
  input logic             done_err,
  input logic [LEN_W-1:0] res_len,
  input logic             accept_evt,
  input logic             stop_evt
);

  p_hold_prim_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prim_valid && !prim_ready |=> prim_valid && $stable(prim_op) && $stable(prim_byte));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !prim_valid && !done);

  p_done_after_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> done);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && cmd_ready);

  p_blk_len_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> res_len <= LEN_W'(BLK_MAX));

  p_unknown_fast_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_err |-> $past(accept_evt));

  p_nack_then_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prim_valid && prim_ready && prim_op == 3'd3 |=> prim_valid && prim_op == 3'd4);

endmodule

bind smbus_cmd_seq smbus_cmd_seq_chk #(.BLK_MAX(BLK_MAX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_ready  (cmd_ready),
  .prim_valid (prim_valid),
  .prim_ready (prim_ready),
  .prim_op    (prim_op),
  .prim_byte  (prim_byte),
  .done       (done),
  .done_err   (done_err),
  .res_len    (res_len),
  .accept_evt (accept_evt),
  .stop_evt   (stop_evt)
);

// File: tb/smbus_cmd_seq_bench.sv
`timescale 1ns/1ps
module smbus_cmd_seq_bench;

  localparam logic [2:0] T_START = 3'd0, T_SEND = 3'd1, T_RECV = 3'd2,
                         T_NACK = 3'd3, T_STOP = 3'd4;

  typedef struct packed {
    logic [3:0]  kind;
    logic [6:0]  addr;
    logic [7:0]  code;
    logic [15:0] wdata;
    logic [7:0]  blen;
    logic        qrd;
    logic [7:0]  r0;
    logic [7:0]  seed;
    logic [15:0] exp_res;
    logic [5:0]  exp_len;
    logic        exp_err;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{4'd0,  7'h12, 8'h00, 16'h0000, 8'd0,  1'b0, 8'h00, 8'h00, 16'h0000, 6'd0,  1'b0},
    '{4'd0,  7'h13, 8'h00, 16'h0000, 8'd0,  1'b1, 8'h00, 8'h00, 16'h0000, 6'd0,  1'b0},
    '{4'd1,  7'h50, 8'hA5, 16'h0000, 8'd0,  1'b0, 8'h00, 8'h00, 16'h0000, 6'd0,  1'b0},
    '{4'd2,  7'h51, 8'h00, 16'h0000, 8'd0,  1'b0, 8'h3C, 8'h00, 16'h003C, 6'd0,  1'b0},
    '{4'd3,  7'h20, 8'h07, 16'h1234, 8'd0,  1'b0, 8'h00, 8'h00, 16'h0000, 6'd0,  1'b0},
    '{4'd4,  7'h21, 8'h08, 16'h0000, 8'd0,  1'b0, 8'h9E, 8'h00, 16'h009E, 6'd0,  1'b0},
    '{4'd5,  7'h22, 8'h09, 16'hBEEF, 8'd0,  1'b0, 8'h00, 8'h00, 16'h0000, 6'd0,  1'b0},
    '{4'd6,  7'h23, 8'h0A, 16'h0000, 8'd0,  1'b0, 8'hCD, 8'hAA, 16'hABCD, 6'd0,  1'b0},
    '{4'd7,  7'h30, 8'h11, 16'h0000, 8'd5,  1'b0, 8'h00, 8'h00, 16'h0000, 6'd5,  1'b0},
    '{4'd7,  7'h31, 8'h12, 16'h0000, 8'd40, 1'b0, 8'h00, 8'h00, 16'h0000, 6'd32, 1'b0},
    '{4'd7,  7'h32, 8'h13, 16'h0000, 8'd0,  1'b0, 8'h00, 8'h00, 16'h0000, 6'd0,  1'b0},
    '{4'd8,  7'h33, 8'h14, 16'h0000, 8'd0,  1'b0, 8'd6,  8'h60, 16'h0000, 6'd6,  1'b0},
    '{4'd8,  7'h34, 8'h15, 16'h0000, 8'd0,  1'b0, 8'd33, 8'h00, 16'h0000, 6'd0,  1'b0},
    '{4'd8,  7'h35, 8'h16, 16'h0000, 8'd0,  1'b0, 8'd32, 8'h10, 16'h0000, 6'd32, 1'b0},
    '{4'd9,  7'h36, 8'h17, 16'h0000, 8'd0,  1'b0, 8'h00, 8'h00, 16'h0000, 6'd0,  1'b1},
    '{4'd15, 7'h37, 8'h18, 16'h0000, 8'd0,  1'b0, 8'h00, 8'h00, 16'h0000, 6'd0,  1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_kind = '0;
  logic [6:0]  cmd_addr = '0;
  logic        cmd_quick_rd = 1'b0;
  logic [7:0]  cmd_code = '0;
  logic [15:0] cmd_wdata = '0;
  logic [7:0]  cmd_blen = '0;
  logic        host_buf_we = 1'b0;
  logic [4:0]  host_buf_widx = '0;
  logic [7:0]  host_buf_wdata = '0;
  logic [4:0]  host_buf_ridx = '0;
  logic [7:0]  host_buf_rdata;
  logic        prim_valid;
  logic        prim_ready = 1'b0;
  logic [2:0]  prim_op;
  logic [7:0]  prim_byte;
  logic [7:0]  prim_rdata = '0;
  logic        done;
  logic        done_err;
  logic [15:0] res_data;
  logic [5:0]  res_len;

  always #2 clk = ~clk;

  smbus_cmd_seq u_smbus_cmd_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_quick_rd(cmd_quick_rd),
    .cmd_code(cmd_code), .cmd_wdata(cmd_wdata), .cmd_blen(cmd_blen),
    .host_buf_we(host_buf_we), .host_buf_widx(host_buf_widx),
    .host_buf_wdata(host_buf_wdata), .host_buf_ridx(host_buf_ridx),
    .host_buf_rdata(host_buf_rdata), .prim_valid(prim_valid),
    .prim_ready(prim_ready), .prim_op(prim_op), .prim_byte(prim_byte),
    .prim_rdata(prim_rdata), .done(done), .done_err(done_err),
    .res_data(res_data), .res_len(res_len)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // responder model of the lower master
  logic [2:0] got_op   [64];
  logic [7:0] got_byte [64];
  int         got_n;
  logic [7:0] rx [64];
  int         rx_idx;
  int         stall_cfg;

  initial begin
    bit         pending = 1'b0;
    int         wait_left = 0;
    logic [2:0] seen_op = '0;
    logic [7:0] seen_byte = '0;
    forever begin
      @(negedge clk);
      if (prim_ready) begin
        prim_ready = 1'b0;
        pending = 1'b0;
      end
      if (rst_n && prim_valid) begin
        if (!pending) begin
          pending   = 1'b1;
          seen_op   = prim_op;
          seen_byte = prim_byte;
          wait_left = stall_cfg;
        end else begin
          chk(prim_op == seen_op && prim_byte == seen_byte, "R9",
              "primitive held while stalled", {prim_op, prim_byte}, {seen_op, seen_byte});
        end
        if (wait_left == 0) begin
          prim_ready = 1'b1;
          if (got_n < 64) begin
            got_op[got_n]   = seen_op;
            got_byte[got_n] = seen_byte;
            got_n++;
          end
          if (seen_op == T_RECV) begin
            prim_rdata = rx[rx_idx];
            rx_idx++;
          end
          pending = 1'b0;
        end else begin
          wait_left--;
        end
      end
    end
  end

  // expected primitive trace, written from the requirements
  logic [2:0] exp_op   [64];
  logic [7:0] exp_byte [64];
  int         exp_n;

  function automatic void push(input logic [2:0] op, input logic [7:0] b);
    exp_op[exp_n]   = op;
    exp_byte[exp_n] = b;
    exp_n++;
  endfunction

  function automatic void build_exp(input vec_t v);
    int n;
    exp_n = 0;
    case (v.kind)
      4'd0: begin push(T_START, {v.addr, v.qrd}); push(T_STOP, 0); end
      4'd1: begin push(T_START, {v.addr, 1'b0}); push(T_SEND, v.code); push(T_STOP, 0); end
      4'd2: begin
        push(T_START, {v.addr, 1'b1}); push(T_RECV, 0); push(T_NACK, 0); push(T_STOP, 0);
      end
      4'd3, 4'd5: begin
        push(T_START, {v.addr, 1'b0}); push(T_SEND, v.code); push(T_SEND, v.wdata[7:0]);
        if (v.kind == 4'd5) push(T_SEND, v.wdata[15:8]);
        push(T_STOP, 0);
      end
      4'd4, 4'd6: begin
        push(T_START, {v.addr, 1'b0}); push(T_SEND, v.code); push(T_START, {v.addr, 1'b1});
        push(T_RECV, 0);
        if (v.kind == 4'd6) push(T_RECV, 0);
        push(T_NACK, 0); push(T_STOP, 0);
      end
      4'd7: begin
        n = (v.blen > 8'd32) ? 32 : int'(v.blen);
        push(T_START, {v.addr, 1'b0}); push(T_SEND, v.code); push(T_SEND, 8'(n));
        for (int i = 0; i < n; i++) push(T_SEND, 8'(8'h40 + i));
        push(T_STOP, 0);
      end
      4'd8: begin
        n = (v.r0 > 8'd32) ? 0 : int'(v.r0);
        push(T_START, {v.addr, 1'b0}); push(T_SEND, v.code); push(T_START, {v.addr, 1'b1});
        push(T_RECV, 0);
        for (int i = 0; i < n; i++) push(T_RECV, 0);
        push(T_NACK, 0); push(T_STOP, 0);
      end
      default: ;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] k);
    case (k)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3, 4'd5: return "R4";
      4'd4, 4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic fill_buf();
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      host_buf_we = 1'b1; host_buf_widx = 5'(i); host_buf_wdata = 8'(8'h40 + i);
    end
    @(negedge clk);
    host_buf_we = 1'b0;
  endtask

  task automatic run_cmd(input vec_t v, input int stall, input bit hold);
    string rq;
    int    t;
    int    n;
    rq = req_of(v.kind);
    if (v.kind == 4'd7) fill_buf();
    rx[0] = v.r0;
    for (int i = 1; i < 64; i++) rx[i] = 8'(v.seed + 8'(i));
    rx_idx = 0; got_n = 0; stall_cfg = stall;
    build_exp(v);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = v.kind; cmd_addr = v.addr; cmd_quick_rd = v.qrd;
    cmd_code = v.code; cmd_wdata = v.wdata; cmd_blen = v.blen;
    @(negedge clk);
    if (hold) begin
      cmd_kind = 4'd0; cmd_addr = 7'h7F; cmd_code = 8'hFF; cmd_wdata = 16'hFFFF;
    end else begin
      cmd_valid = 1'b0;
    end
    chk(cmd_ready == 1'b0, "R10", "cmd_ready low once busy", int'(cmd_ready), 0);
    t = 0;
    while (!done && t < 3000) begin
      @(negedge clk);
      t++;
    end
    cmd_valid = 1'b0;
    if (!done) begin
      chk(1'b0, rq, "completion timeout", 0, 1);
    end else begin
      chk(got_n == exp_n, rq, "primitive count", got_n, exp_n);
      for (int i = 0; i < exp_n && i < got_n; i++) begin
        chk(got_op[i] == exp_op[i], rq, $sformatf("op %0d", i), got_op[i], exp_op[i]);
        if (exp_op[i] == T_START || exp_op[i] == T_SEND)
          chk(got_byte[i] == exp_byte[i], rq, $sformatf("byte %0d", i), got_byte[i], exp_byte[i]);
      end
      chk(res_data == v.exp_res, rq, "res_data", res_data, v.exp_res);
      chk(res_len == v.exp_len, rq, "res_len", res_len, v.exp_len);
      chk(done_err == v.exp_err, rq, "done_err", done_err, v.exp_err);
    end
    @(negedge clk);
    chk(done == 1'b0 && cmd_ready == 1'b1, "R10", "done single pulse then idle",
        {done, cmd_ready}, 2'b01);
    if (v.kind == 4'd8) begin
      n = (v.r0 > 8'd32) ? 0 : int'(v.r0);
      for (int i = 0; i < n; i++) begin
        host_buf_ridx = 5'(i);
        #1;
        chk(host_buf_rdata == 8'(v.seed + 8'(i + 1)), "R7", $sformatf("buffer %0d", i),
            host_buf_rdata, 8'(v.seed + 8'(i + 1)));
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    vec_t d;
    stall_cfg = 0; got_n = 0; rx_idx = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state, R10
    chk(cmd_ready == 1'b1, "R10", "reset cmd_ready", int'(cmd_ready), 1);
    chk(prim_valid == 1'b0, "R10", "reset prim_valid", int'(prim_valid), 0);
    chk(done == 1'b0, "R10", "reset done", int'(done), 0);

    for (int i = 0; i < NV; i++) run_cmd(VEC[i], i % 3, 1'b0);

    // R10: command inputs changed while busy have no effect
    run_cmd(VEC[7], 1, 1'b1);
    @(negedge clk);
    chk(prim_valid == 1'b0 && cmd_ready == 1'b1, "R10", "no second command after hold",
        {prim_valid, cmd_ready}, 2'b01);

    // R9: long stalls on every primitive of a word write
    run_cmd(VEC[6], 6, 1'b0);

    // R6: exactly the buffer size
    d = VEC[8]; d.blen = 8'd32; d.exp_len = 6'd32;
    run_cmd(d, 0, 1'b0);

    // R7: returned length of zero and of 255
    d = VEC[11]; d.r0 = 8'd0; d.exp_len = 6'd0;
    run_cmd(d, 2, 1'b0);
    d = VEC[11]; d.r0 = 8'd255; d.exp_len = 6'd0;
    run_cmd(d, 0, 1'b0);

    // R3: receive byte with stalls
    d = VEC[3]; d.r0 = 8'hF1; d.exp_res = 16'h00F1;
    run_cmd(d, 4, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule